// File: doc/BRIEF.md
# Way-Predicting Set-Associative Cache Lookup

This block is the read lookup path of an 8 KB, four-way set-associative data cache with 32-byte lines and 32-bit byte addresses. It does not wait for a full tag compare before choosing a way. Only a narrow low slice of the tag, called the microtag, is compared in the first cycle. That comparison picks the way whose word is forwarded to the CPU speculatively. One cycle later the remaining high tag bits of that way are compared against the request, and the lookup is reported as a confirmed hit or a miss. If no way matches on the microtag, a miss is flagged at once in the first cycle.

The speculative selection is only sound when the microtag names at most one valid line in a set. The fill port installs a whole line in a single cycle and keeps that rule by placement. A fill whose microtag already belongs to a valid line in the target set overwrites that line. Otherwise a free way is used, and if the set is full the least recently used way is replaced. When the microtag is exactly as wide as the way number, each microtag value owns one fixed way. Line refill from memory, writes and address translation lie outside this block.

Top module: `mtc_cache`

## Requirements
- R1: After reset no line is valid, and `spec_valid`, `spec_miss` and `res_valid` are low until a request is made.
- R2: Address fields: bits [4:2] select the 32-bit word in the line, bits [10:5] the set, and bits [31:11] the 21-bit tag. The microtag is the low `UTAG_W` bits of the tag, starting at address bit 11. The high tag is the remaining `21-UTAG_W` bits.
- R3: One cycle after a request, if a valid line in the set holds the request's microtag, `spec_valid` is 1 and `spec_data` is word k of that line. Word k is bits [32k+31:32k] of the `fill_line` that installed the line.
- R4: One cycle after a request, if no valid line in the set holds its microtag, `spec_miss` is 1 and `spec_valid` is 0. `spec_valid` and `spec_miss` are never high together.
- R5: Two cycles after every request `res_valid` is 1. `res_hit` is 1 only when the microtag matched and the high tag of the forwarded line equals the request's high tag. When the microtag matches a different line, the forwarded word is that line's word and `res_hit` is 0.
- R6: A fill takes one clock edge. A request presented on the following cycle already sees the new line.
- R7: A fill whose microtag equals that of a valid line in the set replaces that line. A set never holds two valid lines with the same microtag.
- R8: A fill with no microtag conflict goes into a free way when the set has one, and no resident line is evicted.
- R9: A fill into a full set with no microtag conflict evicts the least recently used line. Fills and confirmed hits (`res_hit`) count as uses. Speculative matches that fail do not count.
- R10: When `UTAG_W` equals 2, a fill is placed in the way whose number equals its microtag value.
- R11: Sets are independent. A fill changes only the set selected by its own address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 32 | Byte address of the lookup |
| spec_valid | output | 1 | Microtag matched, speculative word valid |
| spec_miss | output | 1 | No microtag match, early miss |
| spec_data | output | 32 | Speculatively forwarded word |
| res_valid | output | 1 | Confirmed result present |
| res_hit | output | 1 | Full tag matched |
| fill_valid | input | 1 | Install a line this cycle |
| fill_addr | input | 32 | Address of the line being installed |
| fill_line | input | 256 | Line contents, word 0 in the low bits |

## Verification
The bench builds two copies side by side from the same stimulus: one with a 3-bit microtag and one with a 2-bit microtag. The 3-bit copy reaches false speculative matches, where the same microtag has different high tags, together with conflict-driven replacement and LRU eviction. The 2-bit copy reaches the fixed-way placement. A bench model keeps line presence and recency with time stamps rather than age counters, and predicts every speculative word, early miss and confirmed hit. It does this over directed corner cases, a sweep over all 64 sets, and a long pseudo-random mix of fills and reads confined to a few sets and a small tag pool so that conflicts are frequent.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned OFF_W   = 5;
  localparam int unsigned IDX_W   = 6;
  localparam int unsigned TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned WAYS    = 4;
  localparam int unsigned WAY_W   = $clog2(WAYS);
  localparam int unsigned WSEL_W  = OFF_W - 2;
  localparam int unsigned LINE_WORDS = 1 << WSEL_W;
  localparam int unsigned LINE_W  = LINE_WORDS * WORD_W;
  localparam int unsigned SETS    = 1 << IDX_W;

  function automatic logic [IDX_W-1:0] addr_index(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [WSEL_W-1:0] addr_word(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1 -: WSEL_W];
  endfunction

  function automatic logic [WORD_W-1:0] word_slice(input logic [LINE_W-1:0] line,
                                                   input logic [WSEL_W-1:0] w);
    return line[w*WORD_W +: WORD_W];
  endfunction

  // lowest set bit of a way vector
  function automatic logic [WAY_W-1:0] onehot_to_idx(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS-1; i >= 0; i--) if (v[i]) r = WAY_W'(i);
    return r;
  endfunction

  // lowest clear bit of a way vector
  function automatic logic [WAY_W-1:0] first_zero(input logic [WAYS-1:0] v);
    return onehot_to_idx(~v);
  endfunction

  // recency age of one way after a touch of some way in the same set
  function automatic logic [WAY_W-1:0] next_age(input logic [WAY_W-1:0] age,
                                                input logic [WAY_W-1:0] touched_age,
                                                input logic is_touched);
    if (is_touched) return '0;
    if (age < touched_age) return age + WAY_W'(1);
    return age;
  endfunction
endpackage

// File: rtl/mtc_tag_store.sv
module mtc_tag_store
  import mtc_pkg::*;
#(
  parameter int unsigned UTAG_W = 3,
  localparam int unsigned HI_W = TAG_W - UTAG_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           rd_index,
  input  logic [UTAG_W-1:0]          rd_utag,
  output logic [WAYS-1:0]            rd_umatch,
  output logic [WAYS-1:0][HI_W-1:0]  rd_hitag,
  input  logic [IDX_W-1:0]           fl_index,
  input  logic [UTAG_W-1:0]          fl_utag,
  output logic [WAYS-1:0]            fl_valid,
  output logic [WAYS-1:0]            fl_umatch,
  input  logic                       wr_en,
  input  logic [WAY_W-1:0]           wr_way,
  input  logic [HI_W-1:0]            wr_hitag
);
  logic [WAYS-1:0]   vld_q [SETS];
  logic [UTAG_W-1:0] ut_q  [SETS][WAYS];
  logic [HI_W-1:0]   hi_q  [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[fl_index][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ut_q[fl_index][wr_way] <= fl_utag;
      hi_q[fl_index][wr_way] <= wr_hitag;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign rd_umatch[w] = vld_q[rd_index][w] && (ut_q[rd_index][w] == rd_utag);
    assign rd_hitag[w]  = hi_q[rd_index][w];
    assign fl_valid[w]  = vld_q[fl_index][w];
    assign fl_umatch[w] = vld_q[fl_index][w] && (ut_q[fl_index][w] == fl_utag);
  end

  // R7
  utag_unique_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_umatch));
  // R7
  utag_unique_fl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fl_umatch));
endmodule

// File: rtl/mtc_data_store.sv
module mtc_data_store
  import mtc_pkg::*;
(
  input  logic               clk,
  input  logic [IDX_W-1:0]   rd_index,
  input  logic [WAY_W-1:0]   rd_way,
  input  logic [WSEL_W-1:0]  rd_word,
  output logic [WORD_W-1:0]  rd_data,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_index,
  input  logic [WAY_W-1:0]   wr_way,
  input  logic [LINE_W-1:0]  wr_line
);
  logic [LINE_W-1:0] line_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (wr_en) line_q[wr_index][wr_way] <= wr_line;
  end

  assign rd_data = word_slice(line_q[rd_index][rd_way], rd_word);
endmodule

// File: rtl/mtc_lru.sv
module mtc_lru
  import mtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              touch_en,
  input  logic [IDX_W-1:0]  touch_index,
  input  logic [WAY_W-1:0]  touch_way,
  input  logic [IDX_W-1:0]  q_index,
  output logic [WAY_W-1:0]  lru_way
);
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  oldest_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++)
        age_q[touch_index][w] <= next_age(age_q[touch_index][w],
                                          age_q[touch_index][touch_way],
                                          WAY_W'(w) == touch_way);
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_old
    assign oldest_vec[w] = (age_q[q_index][w] == WAY_W'(WAYS-1));
  end

  assign lru_way = onehot_to_idx(oldest_vec);

  // R9
  lru_single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);
  // R9
  lru_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> age_q[$past(touch_index)][$past(touch_way)] == '0);
endmodule

// File: rtl/mtc_victim_sel.sv
module mtc_victim_sel
  import mtc_pkg::*;
#(
  parameter int unsigned UTAG_W = 3
) (
  input  logic [WAYS-1:0]   fl_valid,
  input  logic [WAYS-1:0]   fl_umatch,
  input  logic [UTAG_W-1:0] fl_utag,
  input  logic [WAY_W-1:0]  lru_way,
  output logic [WAY_W-1:0]  victim_way,
  output logic              conflict,
  output logic              has_free
);
  assign conflict = |fl_umatch;
  assign has_free = ~&fl_valid;

  if (UTAG_W == WAY_W) begin : g_fixed
    // microtag value names the way directly
    wire unused_fixed = ^{fl_valid, fl_umatch, lru_way};
    assign victim_way = fl_utag[WAY_W-1:0];
  end else begin : g_assoc
    always_comb begin
      if (conflict)      victim_way = onehot_to_idx(fl_umatch);
      else if (has_free) victim_way = first_zero(fl_valid);
      else               victim_way = lru_way;
    end
  end
endmodule

// File: rtl/mtc_cache.sv
module mtc_cache
  import mtc_pkg::*;
#(
  parameter int unsigned UTAG_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                spec_valid,
  output logic                spec_miss,
  output logic [WORD_W-1:0]   spec_data,
  output logic                res_valid,
  output logic                res_hit,
  input  logic                fill_valid,
  input  logic [ADDR_W-1:0]   fill_addr,
  input  logic [LINE_W-1:0]   fill_line
);
  localparam int unsigned HI_W = TAG_W - UTAG_W;

  // request side fields
  logic [IDX_W-1:0]   req_index;
  logic [TAG_W-1:0]   req_tag;
  logic [UTAG_W-1:0]  req_utag;
  logic [HI_W-1:0]    req_hitag;
  logic [WSEL_W-1:0]  req_word;
  assign req_index = addr_index(req_addr);
  assign req_tag   = addr_tag(req_addr);
  assign req_utag  = req_tag[UTAG_W-1:0];
  assign req_hitag = req_tag[TAG_W-1:UTAG_W];
  assign req_word  = addr_word(req_addr);

  // fill side fields
  logic [IDX_W-1:0]   fill_index;
  logic [TAG_W-1:0]   fill_tag;
  logic [UTAG_W-1:0]  fill_utag;
  logic [HI_W-1:0]    fill_hitag;
  assign fill_index = addr_index(fill_addr);
  assign fill_tag   = addr_tag(fill_addr);
  assign fill_utag  = fill_tag[UTAG_W-1:0];
  assign fill_hitag = fill_tag[TAG_W-1:UTAG_W];

  wire unused_low = ^{req_addr[1:0], fill_addr[OFF_W-1:0]};

  // named internal events
  logic [WAYS-1:0]            req_umatch;
  logic [WAYS-1:0][HI_W-1:0]  way_hitag;
  logic                       req_uhit;
  logic [WAY_W-1:0]           req_way;
  logic [WORD_W-1:0]          req_word_data;
  logic [WAYS-1:0]            fill_valid_vec;
  logic [WAYS-1:0]            fill_umatch;
  logic                       fill_conflict;
  logic                       fill_has_free;
  logic [WAY_W-1:0]           victim_way;
  logic [WAY_W-1:0]           lru_way;
  logic                       hi_equal;
  logic                       hit_confirm;
  logic                       touch_en;
  logic [IDX_W-1:0]           touch_index;
  logic [WAY_W-1:0]           touch_way;

  mtc_tag_store #(.UTAG_W(UTAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_index  (req_index),
    .rd_utag   (req_utag),
    .rd_umatch (req_umatch),
    .rd_hitag  (way_hitag),
    .fl_index  (fill_index),
    .fl_utag   (fill_utag),
    .fl_valid  (fill_valid_vec),
    .fl_umatch (fill_umatch),
    .wr_en     (fill_valid),
    .wr_way    (victim_way),
    .wr_hitag  (fill_hitag)
  );

  assign req_uhit = |req_umatch;
  assign req_way  = onehot_to_idx(req_umatch);

  mtc_data_store u_data (
    .clk      (clk),
    .rd_index (req_index),
    .rd_way   (req_way),
    .rd_word  (req_word),
    .rd_data  (req_word_data),
    .wr_en    (fill_valid),
    .wr_index (fill_index),
    .wr_way   (victim_way),
    .wr_line  (fill_line)
  );

  mtc_victim_sel #(.UTAG_W(UTAG_W)) u_victim (
    .fl_valid   (fill_valid_vec),
    .fl_umatch  (fill_umatch),
    .fl_utag    (fill_utag),
    .lru_way    (lru_way),
    .victim_way (victim_way),
    .conflict   (fill_conflict),
    .has_free   (fill_has_free)
  );

  // stage 1: speculative forward
  logic [IDX_W-1:0] s1_index;
  logic [WAY_W-1:0] s1_way;
  logic [HI_W-1:0]  s1_hi_stored;
  logic [HI_W-1:0]  s1_hi_req;
  logic             s1_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_active    <= 1'b0;
      spec_valid   <= 1'b0;
      spec_miss    <= 1'b0;
      spec_data    <= '0;
      s1_index     <= '0;
      s1_way       <= '0;
      s1_hi_stored <= '0;
      s1_hi_req    <= '0;
    end else begin
      s1_active    <= req_valid;
      spec_valid   <= req_valid && req_uhit;
      spec_miss    <= req_valid && !req_uhit;
      spec_data    <= req_uhit ? req_word_data : '0;
      s1_index     <= req_index;
      s1_way       <= req_way;
      s1_hi_stored <= way_hitag[req_way];
      s1_hi_req    <= req_hitag;
    end
  end

  // stage 2: high tag confirmation
  assign hi_equal    = (s1_hi_stored == s1_hi_req);
  assign hit_confirm = spec_valid && hi_equal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
    end else begin
      res_valid <= s1_active;
      res_hit   <= hit_confirm;
    end
  end

  // recency: a fill takes precedence over a confirmed hit in the same cycle
  assign touch_en    = fill_valid || hit_confirm;
  assign touch_index = fill_valid ? fill_index : s1_index;
  assign touch_way   = fill_valid ? victim_way : s1_way;

  mtc_lru u_lru (
    .clk         (clk),
    .rst_n       (rst_n),
    .touch_en    (touch_en),
    .touch_index (touch_index),
    .touch_way   (touch_way),
    .q_index     (fill_index),
    .lru_way     (lru_way)
  );

  // R4
  spec_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(spec_valid && spec_miss));
  // R3
  spec_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (spec_valid || spec_miss));
  // R5
  res_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_valid || spec_miss) |=> res_valid);
  // R5
  res_hit_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> $past(spec_valid));
  // R7
  conflict_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_conflict) |-> fill_umatch[victim_way]);
  // R8
  free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_conflict && fill_has_free) |-> !fill_valid_vec[victim_way]);

  if (UTAG_W == WAY_W) begin : g_fixed_chk
    // R10
    way_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> (victim_way == fill_utag[WAY_W-1:0]));
  end
endmodule

// File: tb/mtc_cache_tb.sv
module mtc_cache_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic         req_valid;
  logic [31:0]  req_addr;
  logic         fill_valid;
  logic [31:0]  fill_addr;
  logic [255:0] fill_line;

  logic         sv [2];
  logic         sm [2];
  logic [31:0]  sd [2];
  logic         rv [2];
  logic         rh [2];

  mtc_cache #(.UTAG_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .spec_valid(sv[0]), .spec_miss(sm[0]), .spec_data(sd[0]),
    .res_valid(rv[0]), .res_hit(rh[0]),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_line(fill_line));

  mtc_cache #(.UTAG_W(2)) u_dut_w2 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .spec_valid(sv[1]), .spec_miss(sm[1]), .spec_data(sd[1]),
    .res_valid(rv[1]), .res_hit(rh[1]),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_line(fill_line));

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model: presence and recency stamps per copy
  bit          m_v   [2][64][4];
  logic [20:0] m_tag [2][64][4];
  int          m_st  [2][64][4];
  int          now = 0;
  logic [31:0] rng = 32'h1234_5678;

  function automatic int uw(int d);
    return (d == 0) ? 3 : 2;
  endfunction

  function automatic logic [31:0] word_of(logic [20:0] t, int s, int w);
    return (32'(t) * 32'h0101_0407) ^ (32'(s) << 22) ^ (32'(w) * 32'h0000_1111) ^ 32'h5A00_0000;
  endfunction

  function automatic int m_find(int d, int s, logic [20:0] t);
    int mask = (1 << uw(d)) - 1;
    for (int j = 0; j < 4; j++)
      if (m_v[d][s][j] && ((int'(m_tag[d][s][j]) & mask) == (int'(t) & mask))) return j;
    return -1;
  endfunction

  function automatic void m_fill(int d, int s, logic [20:0] t);
    int j = m_find(d, s, t);
    if (j < 0) for (int k = 3; k >= 0; k--) if (!m_v[d][s][k]) j = k;
    if (j < 0) begin
      j = 0;
      for (int k = 1; k < 4; k++) if (m_st[d][s][k] < m_st[d][s][j]) j = k;
    end
    now++;
    m_v[d][s][j] = 1'b1;
    m_tag[d][s][j] = t;
    m_st[d][s][j] = now;
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_fill(logic [20:0] t, int s);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_addr = {t, 6'(s), 5'b0};
    for (int w = 0; w < 8; w++) fill_line[w*32 +: 32] = word_of(t, s, w);
    @(negedge clk);
    fill_valid = 1'b0;
    m_fill(0, s, t);
    m_fill(1, s, t);
  endtask

  task automatic do_read(logic [20:0] t, int s, int w, string rq);
    int          slot [2];
    bit          hit  [2];
    logic [31:0] ed   [2];
    for (int d = 0; d < 2; d++) begin
      slot[d] = m_find(d, s, t);
      hit[d]  = (slot[d] >= 0) && (m_tag[d][s][slot[d]] == t);
      ed[d]   = (slot[d] >= 0) ? word_of(m_tag[d][s][slot[d]], s, w) : 32'h0;
    end
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = {t, 6'(s), 3'(w), 2'b00};
    @(negedge clk);
    req_valid = 1'b0;
    for (int d = 0; d < 2; d++) begin
      chk({rq, " R3 spec_valid"}, 32'(sv[d]), 32'(slot[d] >= 0));
      chk({rq, " R4 spec_miss"}, 32'(sm[d]), 32'(slot[d] < 0));
      if (slot[d] >= 0) chk({rq, " R3 spec_data"}, sd[d], ed[d]);
    end
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk({rq, " R5 res_valid"}, 32'(rv[d]), 32'd1);
      chk({rq, " R5 res_hit"}, 32'(rh[d]), 32'(hit[d]));
      if (hit[d]) begin
        now++;
        m_st[d][s][slot[d]] = now;
      end
    end
  endtask

  function automatic logic [31:0] next_rng(logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    fill_valid = 1'b0;
    fill_addr = '0;
    fill_line = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet outputs and empty sets after reset
    for (int d = 0; d < 2; d++) begin
      chk("R1 spec_valid after reset", 32'(sv[d]), 32'd0);
      chk("R1 spec_miss after reset", 32'(sm[d]), 32'd0);
      chk("R1 res_valid after reset", 32'(rv[d]), 32'd0);
    end
    do_read(21'h100, 5, 0, "R1 empty");
    do_read(21'h0, 63, 7, "R1 empty");

    // R6 R2: four lines with distinct microtags, every word read back
    for (int i = 0; i < 4; i++) begin
      do_fill(21'h100 + 21'(i), 5);
      do_read(21'h100 + 21'(i), 5, i, "R6 next-cycle visibility");
    end
    for (int i = 0; i < 4; i++)
      for (int w = 0; w < 8; w++) do_read(21'h100 + 21'(i), 5, w, "R2 word select");

    // R9: touch three lines, then a non-conflicting fill evicts the fourth
    do_read(21'h100, 5, 1, "R9 touch");
    do_read(21'h102, 5, 2, "R9 touch");
    do_read(21'h103, 5, 3, "R9 touch");
    do_fill(21'h104, 5);
    for (int i = 0; i < 5; i++) do_read(21'h100 + 21'(i), 5, 4, "R9 R10 after eviction");

    // R7 R5: same microtag, other high tag replaces; old tag gets wrong-way forward
    do_fill(21'h10C, 5);
    do_read(21'h104, 5, 6, "R7 R5 false speculative match");
    do_read(21'h10C, 5, 6, "R7 replacement present");

    // R8: fourth fill into a set with a free way evicts nothing
    for (int i = 0; i < 3; i++) do_fill(21'h200 + 21'(i), 9);
    do_read(21'h200, 9, 0, "R8 touch");
    do_fill(21'h203, 9);
    for (int i = 0; i < 4; i++) do_read(21'h200 + 21'(i), 9, 5, "R8 free way used");

    // R11: one line per set across all sets, then reread all
    for (int s = 0; s < 64; s++) begin
      do_fill(21'(s * 7 + 1) + 21'h400, s);
      do_read(21'(s * 7 + 1) + 21'h400, s, s % 8, "R11 sweep");
    end
    for (int s = 0; s < 64; s++) do_read(21'(s * 7 + 1) + 21'h400, s, 7 - (s % 8), "R11 isolation");

    // pseudo-random mix in a few sets with a small tag pool
    for (int n = 0; n < 1500; n++) begin
      logic [20:0] t;
      int s;
      rng = next_rng(rng);
      t = 21'(rng[4:0]) | (21'(rng[5]) << 12);
      s = 20 + int'(rng[9:8]);
      if (rng[12:10] < 3'd3) do_fill(t, s);
      else do_read(t, s, int'(rng[15:13]), "R7 R9 mixed");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule